// File: doc/BRIEF.md
# Track-Read Sector Framer

This block wraps each sector of a whole-track read in two framing words. A start request supplies an 8-bit cylinder and an 8-bit head/sector address. The block checks the address first. It then emits a header word built from the cylinder, head and sector. Next it forwards exactly 128 data words from its input stream to its output stream. Last, it emits a control word, which it computes by folding parity nibbles over the forwarded data.

After each control word the address steps to the next sector. The next sector then starts at once. The run ends in one of three ways:
- the head number runs past the last head (long block);
- the starting address is rejected (bad address);
- the channel raises end-of-record (terminated).

At the end of a run, a one-cycle done pulse is raised together with exactly one end-cause flag. The flag is held until the next start.

Top module: `sector_framer`

## Requirements
- R1: After reset, out_valid_o, in_ready_o and done_o are low and all three end-cause flags are low.
- R2: A start whose head field (bits 7:4) is above 10, or whose low nibble (bits 3:0) is above 8, produces no output word. In the cycle after the start it gives done_o with only end_bad_addr_o set.
- R3: Each sector is sent as one header word, then the 128 input data words unchanged and in order, then one control word.
- R4: The header word holds the cylinder bits 7:4 in bits 21:18 and the cylinder bits 3:0 in bits 15:12. It holds the head in bits 9:6 and the sector bits 2:0 in bits 3:1. All other bits are zero.
- R5: Control word bits 15:12 hold the XOR, over the sector's 128 data words, of the nibbles at bits 23:20, 19:16, 15:12, 11:8, 7:4 and 3:0.
- R6: Control word bits 11:8 hold the inverse of the XOR, over the sector's data words, of the nibbles at bits 21:18, 15:12, 9:6 and 3:0. Bit 6 is one and every other bit is zero.
- R7: Both folds restart from zero with each sector's header, so a sector's control word depends only on that sector's data.
- R8: After each control word the address becomes (address + 9) with bit 3 cleared. The next header uses the new head and sector.
- R9: When the advanced head exceeds 10, the run ends right after that control word, with done_o and only end_long_o set.
- R10: eor_i high while a run is active suppresses any transfer in that cycle. The run ends at the next edge with done_o and only end_term_o set, and no further word is sent.
- R11: A header or control word stays valid and unchanged on out_data_o while out_ready_i is low. The folds advance only on data words actually transferred.
- R12: done_o lasts one cycle. The end-cause flags are cleared by the next start and are held until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a track read (taken only while idle) |
| cyl_i | input | 8 | Cylinder number, sampled on start |
| addr_i | input | 8 | Starting head (7:4) and sector (3:0), sampled on start |
| eor_i | input | 1 | Channel end-of-record, aborts an active run |
| in_valid_i | input | 1 | Input data word valid |
| in_ready_o | output | 1 | Input data word accepted |
| in_data_i | input | 24 | Input data word |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Output word accepted |
| out_data_o | output | 24 | Framed output word |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| end_term_o | output | 1 | Run ended by end-of-record |
| end_long_o | output | 1 | Run ended past the last head |
| end_bad_addr_o | output | 1 | Run refused for an out-of-range start address |

## Verification
The assertions assume two things of the surroundings. start_i is only meaningful while the block is idle. During the data phase the upstream source holds its word until it is accepted. The fold-hold and frame-hold properties rely on that second point.

The stimulus drives in_data_i from the bench's own word index. That index advances only on an accepted data beat, so a stalled word is repeated unchanged. The bench raises eor_i for exactly one cycle at a chosen word position and drops it once done_o appears. The ready and valid stall patterns vary per vector, so holds occur in the header, data and control phases.

// File: rtl/sf_pkg.sv
package sf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_CHK
  } sf_state_e;

  localparam int FRAME_W = 24;

  // header field positions
  localparam int HDR_CYL_HI_LSB = 18;
  localparam int HDR_CYL_LO_LSB = 12;
  localparam int HDR_HEAD_LSB   = 6;
  localparam int HDR_SECT_LSB   = 1;

  // check word field positions
  localparam int CW_EVEN_LSB = 12;
  localparam int CW_ODD_LSB  = 8;
  localparam int CW_MARK_BIT = 6;

  function automatic logic [FRAME_W-1:0] build_header(
    input logic [7:0] cyl,
    input logic [3:0] head,
    input logic [2:0] sect
  );
    logic [FRAME_W-1:0] w;
    w = '0;
    w[HDR_CYL_HI_LSB +: 4] = cyl[7:4];
    w[HDR_CYL_LO_LSB +: 4] = cyl[3:0];
    w[HDR_HEAD_LSB +: 4]   = head;
    w[HDR_SECT_LSB +: 3]   = sect;
    return w;
  endfunction

  function automatic logic [FRAME_W-1:0] build_check(
    input logic [3:0] even,
    input logic [3:0] odd
  );
    logic [FRAME_W-1:0] w;
    w = '0;
    w[CW_EVEN_LSB +: 4] = even;
    w[CW_ODD_LSB +: 4]  = ~odd;
    w[CW_MARK_BIT]      = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/sf_fold.sv
module sf_fold #(
  parameter int WORD_W    = 24,
  parameter int NIB_W     = 4,
  parameter int EVEN_STEP = 4,
  parameter int ODD_STEP  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [NIB_W-1:0]  even_o,
  output logic [NIB_W-1:0]  odd_o
);

  localparam int EVEN_N = (WORD_W - NIB_W) / EVEN_STEP + 1;
  localparam int ODD_N  = (WORD_W - NIB_W) / ODD_STEP + 1;

  logic [NIB_W-1:0] even_sl [EVEN_N];
  logic [NIB_W-1:0] odd_sl  [ODD_N];
  logic [NIB_W-1:0] even_w, odd_w;
  logic [NIB_W-1:0] even_q, odd_q;

  for (genvar g = 0; g < EVEN_N; g++) begin : g_even
    assign even_sl[g] = word_i[g*EVEN_STEP +: NIB_W];
  end
  for (genvar g = 0; g < ODD_N; g++) begin : g_odd
    assign odd_sl[g] = word_i[g*ODD_STEP +: NIB_W];
  end

  always_comb begin
    even_w = '0;
    for (int i = 0; i < EVEN_N; i++) even_w ^= even_sl[i];
    odd_w = '0;
    for (int i = 0; i < ODD_N; i++) odd_w ^= odd_sl[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      even_q <= '0;
      odd_q  <= '0;
    end else if (clr_i) begin
      even_q <= '0;
      odd_q  <= '0;
    end else if (en_i) begin
      even_q <= even_q ^ even_w;
      odd_q  <= odd_q ^ odd_w;
    end
  end

  assign even_o = even_q;
  assign odd_o  = odd_q;

  AST_FOLD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (even_q == '0) && (odd_q == '0)); // R7
  AST_FOLD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(even_q) && $stable(odd_q)); // R11
  AST_FOLD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && en_i)); // R7

endmodule

// File: rtl/sf_addr.sv
module sf_addr #(
  parameter int ADDR_W   = 8,
  parameter int SECT_W   = 3,
  parameter int MAX_HEAD = 10,
  parameter int MAX_SECT = 8,
  parameter int STEP     = 9
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [ADDR_W-1:0]            load_val_i,
  input  logic                         adv_i,
  output logic [ADDR_W-SECT_W-2:0]     head_o,
  output logic [SECT_W-1:0]            sect_o,
  output logic                         bad_start_o,
  output logic                         long_next_o
);

  localparam int HEAD_LSB = SECT_W + 1;
  localparam int HEAD_W   = ADDR_W - HEAD_LSB;
  localparam int SLOT_W   = SECT_W + 1;
  localparam logic [ADDR_W-1:0] GAP_MASK = ~(ADDR_W'(1) << SECT_W);

  logic [ADDR_W-1:0] addr_q, addr_next;

  assign addr_next = (addr_q + ADDR_W'(STEP)) & GAP_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (adv_i)  addr_q <= addr_next;
  end

  assign head_o      = addr_q[ADDR_W-1:HEAD_LSB];
  assign sect_o      = addr_q[SECT_W-1:0];
  assign bad_start_o = (load_val_i[ADDR_W-1:HEAD_LSB] > HEAD_W'(MAX_HEAD)) ||
                       (load_val_i[SLOT_W-1:0] > SLOT_W'(MAX_SECT));
  assign long_next_o = addr_next[ADDR_W-1:HEAD_LSB] > HEAD_W'(MAX_HEAD);

  AST_HEAD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (head_o == $past(head_o)) ||
                           (head_o == $past(head_o) + HEAD_W'(1))); // R8

endmodule

// File: rtl/sf_ctrl.sv
module sf_ctrl
  import sf_pkg::*;
#(
  parameter int WORDS = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bad_start_i,
  input  logic long_next_i,
  input  logic eor_i,
  input  logic in_valid_i,
  input  logic out_ready_i,
  output logic out_valid_o,
  output logic in_ready_o,
  output logic hdr_sel_o,
  output logic chk_sel_o,
  output logic fold_clr_o,
  output logic fold_en_o,
  output logic addr_load_o,
  output logic addr_adv_o,
  output logic done_o,
  output logic end_term_o,
  output logic end_long_o,
  output logic end_bad_addr_o
);

  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  sf_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q, term_q, long_q, bad_q;
  logic             active, cut, xfer;

  assign active      = state_q != ST_IDLE;
  assign cut         = active && eor_i;
  assign out_valid_o = !cut && ((state_q == ST_HDR) || (state_q == ST_CHK) ||
                                ((state_q == ST_DATA) && in_valid_i));
  assign in_ready_o  = (state_q == ST_DATA) && !eor_i && out_ready_i;
  assign xfer        = out_valid_o && out_ready_i;
  assign hdr_sel_o   = state_q == ST_HDR;
  assign chk_sel_o   = state_q == ST_CHK;
  assign fold_clr_o  = hdr_sel_o && xfer;
  assign fold_en_o   = (state_q == ST_DATA) && xfer;
  assign addr_load_o = (state_q == ST_IDLE) && start_i;
  assign addr_adv_o  = chk_sel_o && xfer;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      term_q  <= 1'b0;
      long_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          term_q <= 1'b0;
          long_q <= 1'b0;
          bad_q  <= bad_start_i;
          if (bad_start_i) done_q  <= 1'b1;
          else             state_q <= ST_HDR;
        end
      end else if (eor_i) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
        term_q  <= 1'b1;
      end else if (xfer) begin
        unique case (state_q)
          ST_HDR: begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
          end
          ST_DATA: begin
            if (cnt_q == LAST) state_q <= ST_CHK;
            else               cnt_q   <= cnt_q + CNT_W'(1);
          end
          ST_CHK: begin
            if (long_next_i) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              long_q  <= 1'b1;
            end else begin
              state_q <= ST_HDR;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o         = done_q;
  assign end_term_o     = term_q;
  assign end_long_o     = long_q;
  assign end_bad_addr_o = bad_q;

  AST_LAST_TO_CHK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fold_en_o && cnt_q == LAST) |=> state_q == ST_CHK); // R3
  AST_HDR_TO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fold_clr_o |=> (state_q == ST_DATA) && (cnt_q == '0)); // R3
  AST_EOR_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cut |=> (state_q == ST_IDLE) && done_q && term_q && !long_q); // R10
  AST_BAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_load_o && bad_start_i) |=> done_q && bad_q && (state_q == ST_IDLE)); // R2
  AST_LONG_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_adv_o && long_next_i) |=> done_q && long_q && (state_q == ST_IDLE)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !out_valid_o && !in_ready_o); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !(addr_load_o && bad_start_i)) |=> !done_q); // R12

endmodule

// File: rtl/sector_framer.sv
module sector_framer
  import sf_pkg::*;
#(
  parameter int WORD_W   = sf_pkg::FRAME_W,
  parameter int CYL_W    = 8,
  parameter int ADDR_W   = 8,
  parameter int SECT_W   = 3,
  parameter int WORDS    = 128,
  parameter int MAX_HEAD = 10,
  parameter int MAX_SECT = 8,
  parameter int STEP     = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              eor_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              done_o,
  output logic              end_term_o,
  output logic              end_long_o,
  output logic              end_bad_addr_o
);

  localparam int HEAD_W = ADDR_W - SECT_W - 1;

  logic [CYL_W-1:0]  cyl_q;
  logic [HEAD_W-1:0] head;
  logic [SECT_W-1:0] sect;
  logic [3:0]        even, odd;
  logic bad_start, long_next, hdr_sel, chk_sel;
  logic fold_clr, fold_en, addr_load, addr_adv;
  logic [FRAME_W-1:0] hdr_word, chk_word;

  sf_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .bad_start_i    (bad_start),
    .long_next_i    (long_next),
    .eor_i          (eor_i),
    .in_valid_i     (in_valid_i),
    .out_ready_i    (out_ready_i),
    .out_valid_o    (out_valid_o),
    .in_ready_o     (in_ready_o),
    .hdr_sel_o      (hdr_sel),
    .chk_sel_o      (chk_sel),
    .fold_clr_o     (fold_clr),
    .fold_en_o      (fold_en),
    .addr_load_o    (addr_load),
    .addr_adv_o     (addr_adv),
    .done_o         (done_o),
    .end_term_o     (end_term_o),
    .end_long_o     (end_long_o),
    .end_bad_addr_o (end_bad_addr_o)
  );

  sf_addr #(
    .ADDR_W   (ADDR_W),
    .SECT_W   (SECT_W),
    .MAX_HEAD (MAX_HEAD),
    .MAX_SECT (MAX_SECT),
    .STEP     (STEP)
  ) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (addr_load),
    .load_val_i  (addr_i),
    .adv_i       (addr_adv),
    .head_o      (head),
    .sect_o      (sect),
    .bad_start_o (bad_start),
    .long_next_o (long_next)
  );

  sf_fold #(
    .WORD_W    (WORD_W),
    .NIB_W     (4),
    .EVEN_STEP (4),
    .ODD_STEP  (6)
  ) u_fold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fold_clr),
    .en_i   (fold_en),
    .word_i (in_data_i),
    .even_o (even),
    .odd_o  (odd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cyl_q <= '0;
    else if (addr_load) cyl_q <= cyl_i;
  end

  assign hdr_word = build_header(8'(cyl_q), 4'(head), 3'(sect));
  assign chk_word = build_check(even, odd);

  always_comb begin
    if (hdr_sel)      out_data_o = WORD_W'(hdr_word);
    else if (chk_sel) out_data_o = WORD_W'(chk_word);
    else              out_data_o = in_data_i;
  end

  AST_HOLD_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hdr_sel || chk_sel) && out_valid_o && !out_ready_i && !eor_i)
      |=> $stable(out_data_o) && (hdr_sel || chk_sel)); // R11
  AST_ONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({end_term_o, end_long_o, end_bad_addr_o}) == 1); // R12

endmodule

// File: tb/sector_framer_tb.sv
module sector_framer_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  cyl_i = '0;
  logic [7:0]  addr_i = '0;
  logic        eor_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [23:0] in_data_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [23:0] out_data_o;
  logic        done_o, end_term_o, end_long_o, end_bad_addr_o;

  int tests = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  sector_framer u_dut (
    .clk_i, .rst_ni, .start_i, .cyl_i, .addr_i, .eor_i,
    .in_valid_i, .in_ready_o, .in_data_i,
    .out_valid_o, .out_ready_i, .out_data_o,
    .done_o, .end_term_o, .end_long_o, .end_bad_addr_o
  );

  typedef struct packed {
    logic [7:0]  cyl;
    logic [7:0]  addr;
    logic [23:0] seed;
    logic [15:0] eor_at;   // word position of end-of-record, FFFF = none
    logic [1:0]  stall;
    logic [7:0]  nsect;    // complete sectors expected
    logic [1:0]  cause;    // 0 long, 1 term, 2 bad address
    logic [23:0] hdr0;
    logic [23:0] ctrl0;    // FFFFFF = not anchored
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 8'hA7, 24'h000000, 16'hFFFF, 2'd0, 8'd1, 2'd0, 24'h28528E, 24'h001E40},
    '{8'h3C, 8'hA6, 24'h123457, 16'hFFFF, 2'd1, 8'd2, 2'd0, 24'h0CC28C, 24'hFFFFFF},
    '{8'h00, 8'hA8, 24'h000000, 16'hFFFF, 2'd2, 8'd1, 2'd0, 24'h000280, 24'h001E40},
    '{8'hFF, 8'h97, 24'hABCDEF, 16'hFFFF, 2'd2, 8'd9, 2'd0, 24'h3CF24E, 24'hFFFFFF},
    '{8'h12, 8'hB0, 24'h000001, 16'hFFFF, 2'd0, 8'd0, 2'd2, 24'h000000, 24'hFFFFFF},
    '{8'h12, 8'h09, 24'h000001, 16'hFFFF, 2'd0, 8'd0, 2'd2, 24'h000000, 24'hFFFFFF},
    '{8'h40, 8'hA0, 24'h00F00F, 16'd40,   2'd1, 8'd0, 2'd1, 24'h100280, 24'hFFFFFF},
    '{8'h07, 8'hA7, 24'h000005, 16'd0,    2'd0, 8'd0, 2'd1, 24'h00728E, 24'hFFFFFF},
    '{8'h07, 8'hA7, 24'h000005, 16'd129,  2'd0, 8'd0, 2'd1, 24'h00728E, 24'hFFFFFF},
    '{8'h21, 8'hA7, 24'hFFFFFF, 16'hFFFF, 2'd1, 8'd1, 2'd0, 24'h08128E, 24'h000F40}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] gen(input logic [23:0] seed, input int i);
    logic [47:0] p;
    if (seed == 24'h0) return (i == 0) ? 24'h000001 : 24'h0;
    if (seed == 24'hFFFFFF) return 24'hFFFFFF;
    p = 48'(seed) * 48'(i + 7);
    return p[23:0] ^ 24'(i << 11);
  endfunction

  function automatic logic [23:0] model_hdr(input logic [7:0] c, input logic [7:0] a);
    return {2'b00, c[7:4], 2'b00, c[3:0], 2'b00, a[7:4], 2'b00, a[2:0], 1'b0};
  endfunction

  task automatic run_vec(input vec_t v, input int vn);
    int pos = 0, idx = 0, sect = 0, kk = 0, cyc = 0;
    int data_bad = 0, hold_bad = 0, eor_bad = 0;
    logic [23:0] bad_act = '0, bad_exp = '0, ex, w, held_val = '0;
    logic [7:0] a = v.addr;
    logic [3:0] e = '0, o = '0;
    bit held = 0, fin = 0;
    logic [2:0] flags;
    @(negedge clk_i);
    start_i = 1'b1; cyl_i = v.cyl; addr_i = v.addr;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    if (v.cause == 2'd2) begin
      check(done_o && end_bad_addr_o && !end_long_o && !end_term_o && !out_valid_o,
            $sformatf("R2 bad start vec%0d", vn),
            {done_o, end_bad_addr_o, end_long_o, end_term_o, out_valid_o}, 5'b11000);
      fin = 1;
    end
    while (!fin && cyc < 20000) begin
      @(negedge clk_i);
      cyc++;
      case (v.stall)
        2'd1: begin out_ready_i = (cyc % 3) != 0; in_valid_i = 1'b1; end
        2'd2: begin out_ready_i = (cyc % 2) != 0; in_valid_i = (cyc % 5) != 0; end
        default: begin out_ready_i = 1'b1; in_valid_i = 1'b1; end
      endcase
      in_data_i = gen(v.seed, idx);
      eor_i = (kk == int'(v.eor_at));
      #1;
      if (held && !eor_i && (!out_valid_o || out_data_o != held_val)) hold_bad++;
      held = 0;
      if (eor_i) begin
        if (out_valid_o || in_ready_o) eor_bad++;
      end else if (out_valid_o && out_ready_i) begin
        if (pos == 0) begin
          ex = model_hdr(v.cyl, a);
          if (sect == 0)
            check(out_data_o == v.hdr0, $sformatf("R4 header vec%0d", vn), out_data_o, v.hdr0);
          else
            check(out_data_o == ex, $sformatf("R8 next header vec%0d s%0d", vn, sect),
                  out_data_o, ex);
          e = '0; o = '0; pos = 1;
        end else if (pos <= 128) begin
          w = gen(v.seed, idx);
          if (out_data_o != w) begin
            if (data_bad == 0) begin bad_act = out_data_o; bad_exp = w; end
            data_bad++;
          end
          e ^= w[23:20] ^ w[19:16] ^ w[15:12] ^ w[11:8] ^ w[7:4] ^ w[3:0];
          o ^= w[21:18] ^ w[15:12] ^ w[9:6] ^ w[3:0];
          idx++; pos++;
        end else begin
          ex = {8'h00, e, ~o, 2'b01, 6'b000000};
          if (sect == 0 && v.ctrl0 != 24'hFFFFFF)
            check(out_data_o == v.ctrl0, $sformatf("R5,R6 anchored check word vec%0d", vn),
                  out_data_o, v.ctrl0);
          else
            check(out_data_o == ex, $sformatf("R5,R6,R7,R11 check word vec%0d s%0d", vn, sect),
                  out_data_o, ex);
          sect++; a = (a + 8'd9) & 8'hF7; pos = 0; idx = 0;
        end
        kk++;
      end else if (out_valid_o && (pos == 0 || pos == 129)) begin
        held = 1; held_val = out_data_o;
      end
      @(posedge clk_i); #1;
      if (done_o) fin = 1;
    end
    eor_i = 1'b0;
    flags = {end_long_o, end_term_o, end_bad_addr_o};
    if (v.cause != 2'd2) begin
      check(fin, $sformatf("R9 R10 run ended vec%0d", vn), 32'(fin), 1);
      check(sect == int'(v.nsect), $sformatf("R9 R10 sector count vec%0d", vn), sect, v.nsect);
      check(flags == ((v.cause == 2'd0) ? 3'b100 : 3'b010),
            $sformatf("R9 R10 end cause vec%0d", vn), flags,
            (v.cause == 2'd0) ? 3'b100 : 3'b010);
      check(data_bad == 0, $sformatf("R3 data passthrough vec%0d", vn), bad_act, bad_exp);
      check(eor_bad == 0, $sformatf("R10 no transfer on eor vec%0d", vn), eor_bad, 0);
      if (v.stall != 2'd0)
        check(hold_bad == 0, $sformatf("R11 frame word hold vec%0d", vn), hold_bad, 0);
    end
    @(posedge clk_i); #1;
    check(!done_o && {end_long_o, end_term_o, end_bad_addr_o} == flags && !out_valid_o,
          $sformatf("R12 done pulse and held flags vec%0d", vn),
          {done_o, end_long_o, end_term_o, end_bad_addr_o, out_valid_o}, {1'b0, flags, 1'b0});
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check(!out_valid_o && !in_ready_o && !done_o && !end_term_o && !end_long_o &&
          !end_bad_addr_o, "R1 in reset",
          {out_valid_o, in_ready_o, done_o, end_term_o, end_long_o, end_bad_addr_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    out_ready_i = 1'b1; in_valid_i = 1'b1;
    @(posedge clk_i); #1;
    check(!out_valid_o && !in_ready_o && !done_o, "R1 idle after reset",
          {out_valid_o, in_ready_o, done_o}, 0);

    for (int n = 0; n < NVEC; n++) run_vec(VECS[n], n);

    // directed: start clears a previous cause (long follows bad)
    run_vec(VECS[5], 50);
    run_vec(VECS[2], 52);
    check(end_long_o && !end_bad_addr_o, "R12 flags cleared by start",
          {end_long_o, end_bad_addr_o}, 2'b10);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule